// File: doc/BRIEF.md
# Byte/Word ALU with Decimal Add

This block is the data-operation unit of a small 16-bit core. It is purely combinational: the core presents a source operand, a destination operand, the current carry flag, a 4-bit operation code and a byte/word select. In the same cycle it returns the computed value, a flag telling the core whether that value is stored back to the destination, and the carry, zero, negative and overflow flags with their own update enable.

The unit covers binary add and subtract with and without carry, packed-BCD addition with carry, compare and bit-test (flags only, no store), the bitwise set, clear, AND, XOR and move operations, and the single-operand right shifts, byte swap and sign extension. Single-operand operations work on the destination operand. In byte mode the unit uses only the low eight bits of each operand, clears the upper byte of the result, and takes every flag from the low byte. Byte swap and sign extension always work on the full word.

No pins carry a data stream, so there is no valid/ready handshake. The outputs follow the inputs combinationally, and the core samples them on its own clock.

Top module: `bb_alu`

## Requirements
- R1: `op_i` encodes ADD=0, ADDC=1, DADD=2, SUB=3, SUBC=4, CMP=5, AND=6, BIT=7, BIC=8, BIS=9, XOR=10, MOV=11, RRA=12, RRC=13, SWPB=14, SXT=15. `wr_en_o` is 0 for CMP and BIT and 1 for every other code.
- R2: ADD gives dst+src and ADDC gives dst+src+carry_i. C is the carry out of the active MSB. V is set when both addends have the same sign and the result's sign differs from it.
- R3: SUB gives dst+~src+1, SUBC gives dst+~src+carry_i, and CMP computes the same value as SUB. C=1 means no borrow, so after SUB C equals (dst >= src) unsigned. V is the signed overflow of that sum.
- R4: DADD adds src, dst and carry_i as packed BCD digits. Any digit sum above 9 is corrected by adding 6 and carries into the next digit. C is the carry out of the top active digit, and V is 0.
- R5: AND and BIT give src&dst, and XOR gives src^dst. For these three, C is the inverse of Z. V is 0, except for XOR, where V=1 when both operands' active MSBs are 1.
- R6: BIC gives ~src&dst, BIS gives src|dst and MOV gives src. For these and SWPB, `flags_we_o` is 0 and the flag outputs read 0. Every other operation drives `flags_we_o` to 1.
- R7: RRA shifts dst right one place and keeps the active MSB. RRC shifts carry_i into the active MSB. For both, C is the old bit 0 and V is 0.
- R8: SWPB exchanges bits 15:8 and 7:0. SXT copies bit 7 into bits 15:8, and sets C to NOT Z and V to 0. Both ignore `byte_i`.
- R9: With `byte_i`=1, every operation except SWPB and SXT uses only operand bits 7:0, returns bits 15:8 as 0, and takes its carry from bit 7.
- R10: When `flags_we_o` is 1, N equals the active MSB of `result_o` (bit 7 in byte mode, else bit 15) and Z is 1 exactly when the active part of `result_o` is zero. With all inputs zero, the result is 0 and the flags are C=0, Z=1, N=0, V=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand; the only operand of single-operand operations |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code (encoding in R1) |
| byte_i | input | 1 | 1 selects byte width, 0 word width |
| result_o | output | 16 | Computed value (also driven for CMP and BIT) |
| wr_en_o | output | 1 | Result is to be stored to the destination |
| flags_we_o | output | 1 | Flag outputs are to be stored |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The embedded assertions watch, for every input combination the block is given, the following general properties:
- upper-byte clearing in byte mode, and the agreement of N and Z with the value on `result_o`;
- the borrow meaning of C after SUB;
- the AND result as a subset of both operands;
- sign duplication after RRA;
- digits that stay in 0–9 when DADD is fed valid BCD.

Exact values need the directed scenarios:
- signed overflow on the boundary words and bytes;
- digit correction and carry ripple through a chain of nines;
- carry_i entering RRC and the carry forms of add and subtract;
- the XOR overflow rule;
- which operations suppress the store or the flag update.

// File: rtl/bb_alu_pkg.sv
`timescale 1ns/1ps
package bb_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_DADD = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBC = 4'd4,
    OP_CMP  = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_MOV  = 4'd11,
    OP_RRA  = 4'd12,
    OP_RRC  = 4'd13,
    OP_SWPB = 4'd14,
    OP_SXT  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/bb_alu_addsub.sv
`timescale 1ns/1ps
module bb_alu_addsub
  import bb_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              carry_i,
  input  alu_op_e           op_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output alu_flags_t        flags_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] a_m, b_m;
  logic [DATA_W:0]   sum;
  logic              inv_src, cin_eff;
  logic              a_s, b_s, r_s;

  assign lane_mask = byte_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};

  always_comb begin
    inv_src = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
    case (op_i)
      OP_ADD:         cin_eff = 1'b0;
      OP_SUB, OP_CMP: cin_eff = 1'b1;
      default:        cin_eff = carry_i;
    endcase
  end

  // Inversion happens before masking so the byte lane sees ~src[7:0] only.
  assign a_m = dst_i & lane_mask;
  assign b_m = (inv_src ? ~src_i : src_i) & lane_mask;
  assign sum = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin_eff};

  assign res_o = sum[DATA_W-1:0] & lane_mask;
  assign a_s   = byte_i ? a_m[HALF_W-1]   : a_m[DATA_W-1];
  assign b_s   = byte_i ? b_m[HALF_W-1]   : b_m[DATA_W-1];
  assign r_s   = byte_i ? res_o[HALF_W-1] : res_o[DATA_W-1];

  always_comb begin
    flags_o.c = byte_i ? sum[HALF_W] : sum[DATA_W];
    flags_o.z = (res_o == '0);
    flags_o.n = r_s;
    flags_o.v = (a_s == b_s) && (r_s != a_s);
  end

  // R3: after a plain subtract, carry set means no borrow occurred.
  always_comb begin
    if (op_i == OP_SUB) begin
      a_r3_sub_no_borrow: assert (flags_o.c == ((dst_i & lane_mask) >= (src_i & lane_mask)))
        else $error("a_r3_sub_no_borrow");
    end
  end

endmodule

// File: rtl/bb_alu_bcd.sv
`timescale 1ns/1ps
module bb_alu_bcd #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              carry_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              z_o,
  output logic              n_o
);
  localparam int HALF_W   = DATA_W / 2;
  localparam int NDIG     = DATA_W / 4;
  localparam int HALF_DIG = NDIG / 2;

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] a_m, b_m, sum_d;
  logic [NDIG:0]     cy;

  assign lane_mask = byte_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
  assign a_m = dst_i & lane_mask;
  assign b_m = src_i & lane_mask;

  // Digit ripple: each nibble above 9 is pushed back into range by +6.
  always_comb begin
    logic [4:0] raw;
    cy[0] = carry_i;
    sum_d = '0;
    for (int d = 0; d < NDIG; d++) begin
      raw = {1'b0, a_m[4*d +: 4]} + {1'b0, b_m[4*d +: 4]} + {4'b0000, cy[d]};
      if (raw > 5'd9) begin
        cy[d+1]          = 1'b1;
        sum_d[4*d +: 4]  = raw[3:0] + 4'd6;
      end else begin
        cy[d+1]          = 1'b0;
        sum_d[4*d +: 4]  = raw[3:0];
      end
    end
  end

  assign res_o = sum_d & lane_mask;
  assign c_o   = byte_i ? cy[HALF_DIG] : cy[NDIG];
  assign z_o   = (res_o == '0);
  assign n_o   = byte_i ? res_o[HALF_W-1] : res_o[DATA_W-1];

  logic in_bcd;
  always_comb begin
    in_bcd = 1'b1;
    for (int d = 0; d < NDIG; d++) begin
      if (src_i[4*d +: 4] > 4'd9 || dst_i[4*d +: 4] > 4'd9) in_bcd = 1'b0;
    end
  end

  // R4: valid BCD in gives valid BCD out, digit by digit.
  for (genvar g = 0; g < NDIG; g++) begin : g_digit_chk
    always_comb begin
      if (in_bcd) begin
        a_r4_bcd_digit: assert (res_o[4*g +: 4] <= 4'd9)
          else $error("a_r4_bcd_digit");
      end
    end
  end

endmodule

// File: rtl/bb_alu_logic.sv
`timescale 1ns/1ps
module bb_alu_logic
  import bb_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  alu_op_e           op_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output alu_flags_t        flags_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] raw;
  logic              s_top, d_top;

  assign lane_mask = byte_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};

  always_comb begin
    case (op_i)
      OP_AND, OP_BIT: raw = src_i & dst_i;
      OP_BIC:         raw = ~src_i & dst_i;
      OP_BIS:         raw = src_i | dst_i;
      OP_XOR:         raw = src_i ^ dst_i;
      default:        raw = src_i;
    endcase
  end

  assign res_o = raw & lane_mask;
  assign s_top = byte_i ? src_i[HALF_W-1] : src_i[DATA_W-1];
  assign d_top = byte_i ? dst_i[HALF_W-1] : dst_i[DATA_W-1];

  always_comb begin
    flags_o.z = (res_o == '0);
    flags_o.n = byte_i ? res_o[HALF_W-1] : res_o[DATA_W-1];
    flags_o.c = ~flags_o.z;
    flags_o.v = (op_i == OP_XOR) && s_top && d_top;
  end

  // R5: an AND result never holds a bit absent from either operand.
  always_comb begin
    if (op_i == OP_AND) begin
      a_r5_and_subset: assert (((res_o & ~src_i) == '0) && ((res_o & ~dst_i) == '0))
        else $error("a_r5_and_subset");
    end
  end

endmodule

// File: rtl/bb_alu_shift.sv
`timescale 1ns/1ps
module bb_alu_shift
  import bb_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic              carry_i,
  input  alu_op_e           op_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output alu_flags_t        flags_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] lane_mask, d_m, shr;
  logic              top_in;
  logic              whole;

  assign lane_mask = byte_i ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
  assign d_m       = dst_i & lane_mask;
  assign top_in    = (op_i == OP_RRC) ? carry_i
                   : (byte_i ? d_m[HALF_W-1] : d_m[DATA_W-1]);

  always_comb begin
    shr = d_m >> 1;
    if (byte_i) shr[HALF_W-1] = top_in;
    else        shr[DATA_W-1] = top_in;
  end

  // Byte swap and sign extension are word-only operations.
  assign whole = (op_i == OP_SWPB) || (op_i == OP_SXT);

  always_comb begin
    case (op_i)
      OP_SWPB: res_o = {dst_i[HALF_W-1:0], dst_i[DATA_W-1:HALF_W]};
      OP_SXT:  res_o = {{HALF_W{dst_i[HALF_W-1]}}, dst_i[HALF_W-1:0]};
      default: res_o = shr;
    endcase
  end

  always_comb begin
    flags_o.z = (res_o == '0);
    flags_o.n = (byte_i && !whole) ? res_o[HALF_W-1] : res_o[DATA_W-1];
    flags_o.c = (op_i == OP_SXT) ? ~flags_o.z : d_m[0];
    flags_o.v = 1'b0;
  end

  // R7: an arithmetic right shift leaves the two top lane bits equal.
  always_comb begin
    if (op_i == OP_RRA) begin
      a_r7_rra_sign_copy: assert (byte_i ? (res_o[HALF_W-1] == res_o[HALF_W-2])
                                         : (res_o[DATA_W-1] == res_o[DATA_W-2]))
        else $error("a_r7_rra_sign_copy");
    end
  end

endmodule

// File: rtl/bb_alu.sv
`timescale 1ns/1ps
module bb_alu
  import bb_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [15:0] src_i,
  input  logic [15:0] dst_i,
  input  logic        carry_i,
  input  logic [3:0]  op_i,
  input  logic        byte_i,
  output logic [15:0] result_o,
  output logic        wr_en_o,
  output logic        flags_we_o,
  output logic        flag_c_o,
  output logic        flag_z_o,
  output logic        flag_n_o,
  output logic        flag_v_o
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic [DATA_W-1:0] as_res, bcd_res, lg_res, sh_res;
  alu_flags_t        as_fl, lg_fl, sh_fl, bcd_fl, sel_fl;
  logic              bcd_c, bcd_z, bcd_n;

  assign op = alu_op_e'(op_i);

  bb_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .src_i(src_i), .dst_i(dst_i), .carry_i(carry_i), .op_i(op),
    .byte_i(byte_i), .res_o(as_res), .flags_o(as_fl)
  );

  bb_alu_bcd #(.DATA_W(DATA_W)) u_bcd (
    .src_i(src_i), .dst_i(dst_i), .carry_i(carry_i), .byte_i(byte_i),
    .res_o(bcd_res), .c_o(bcd_c), .z_o(bcd_z), .n_o(bcd_n)
  );

  bb_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .src_i(src_i), .dst_i(dst_i), .op_i(op), .byte_i(byte_i),
    .res_o(lg_res), .flags_o(lg_fl)
  );

  bb_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .dst_i(dst_i), .carry_i(carry_i), .op_i(op), .byte_i(byte_i),
    .res_o(sh_res), .flags_o(sh_fl)
  );

  always_comb begin
    bcd_fl.c = bcd_c;
    bcd_fl.z = bcd_z;
    bcd_fl.n = bcd_n;
    bcd_fl.v = 1'b0;
  end

  always_comb begin
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        result_o = as_res;  sel_fl = as_fl;
      end
      OP_DADD: begin
        result_o = bcd_res; sel_fl = bcd_fl;
      end
      OP_AND, OP_BIT, OP_BIC, OP_BIS, OP_XOR, OP_MOV: begin
        result_o = lg_res;  sel_fl = lg_fl;
      end
      default: begin
        result_o = sh_res;  sel_fl = sh_fl;
      end
    endcase
  end

  assign wr_en_o    = !((op == OP_CMP) || (op == OP_BIT));
  assign flags_we_o = !((op == OP_BIC) || (op == OP_BIS) || (op == OP_MOV) || (op == OP_SWPB));

  assign flag_c_o = flags_we_o & sel_fl.c;
  assign flag_z_o = flags_we_o & sel_fl.z;
  assign flag_n_o = flags_we_o & sel_fl.n;
  assign flag_v_o = flags_we_o & sel_fl.v;

  // R9: byte operations other than swap/extend never leave upper bits set.
  always_comb begin
    if (byte_i && (op != OP_SWPB) && (op != OP_SXT)) begin
      a_r9_upper_clear: assert (result_o[DATA_W-1:HALF_W] == '0)
        else $error("a_r9_upper_clear");
    end
  end

  // R10: Z and N agree with the value the mux delivers.
  always_comb begin
    if (flags_we_o) begin
      a_r10_zero_flag: assert (flag_z_o == (byte_i ? (result_o[HALF_W-1:0] == '0)
                                                   : (result_o == '0)))
        else $error("a_r10_zero_flag");
      a_r10_neg_flag: assert (flag_n_o == (byte_i ? result_o[HALF_W-1] : result_o[DATA_W-1]))
        else $error("a_r10_neg_flag");
    end
  end

endmodule

// File: tb/sim_bb_alu.sv
`timescale 1ns/1ps
module sim_bb_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src, dst;
  logic        cin, bsel;
  logic [3:0]  op;
  logic [15:0] result;
  logic        wr_en, flags_we, fc, fz, fn, fv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bb_alu u0 (
    .src_i(src), .dst_i(dst), .carry_i(cin), .op_i(op), .byte_i(bsel),
    .result_o(result), .wr_en_o(wr_en), .flags_we_o(flags_we),
    .flag_c_o(fc), .flag_z_o(fz), .flag_n_o(fn), .flag_v_o(fv)
  );

  localparam logic [3:0] ADD=0, ADDC=1, DADD=2, SUB=3, SUBC=4, CMP=5, AND_=6, BIT=7,
                         BIC=8, BIS=9, XOR_=10, MOV=11, RRA=12, RRC=13, SWPB=14, SXT=15;

  task automatic chk(input string tag, input string what, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Flags expected as {C,Z,N,V}; only compared when the update enable is expected.
  task automatic run(input string tag, input logic [3:0] o, input logic [15:0] s,
                     input logic [15:0] d, input logic c, input logic b,
                     input logic [15:0] e_res, input logic e_we, input logic e_fwe,
                     input logic [3:0] e_fl);
    @(negedge clk);
    op = o; src = s; dst = d; cin = c; bsel = b;
    #1;
    chk(tag, "result", result, e_res);
    chk(tag, "wr_en", {15'd0, wr_en}, {15'd0, e_we});
    chk(tag, "flags_we", {15'd0, flags_we}, {15'd0, e_fwe});
    if (e_fwe) chk(tag, "CZNV", {12'd0, fc, fz, fn, fv}, {12'd0, e_fl});
  endtask

  task automatic t_idle();
    run("R10 all-zero inputs", ADD, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1, 1, 4'b0100);
  endtask

  task automatic t_add();
    run("R2 add signed overflow", ADD, 16'h0001, 16'h7FFF, 0, 0, 16'h8000, 1, 1, 4'b0011);
    run("R2 add wrap carry",      ADD, 16'h0001, 16'hFFFF, 0, 0, 16'h0000, 1, 1, 4'b1100);
    run("R2 addc with carry",     ADDC, 16'h1234, 16'h1111, 1, 0, 16'h2346, 1, 1, 4'b0000);
    run("R2 add carry_i ignored", ADD, 16'h1234, 16'h1111, 1, 0, 16'h2345, 1, 1, 4'b0000);
  endtask

  task automatic t_sub();
    run("R3 sub borrow",          SUB, 16'h0007, 16'h0005, 0, 0, 16'hFFFE, 1, 1, 4'b0010);
    run("R3 sub no borrow",       SUB, 16'h0005, 16'h0007, 0, 0, 16'h0002, 1, 1, 4'b1000);
    run("R3 subc carry clear",    SUBC, 16'h0005, 16'h0007, 0, 0, 16'h0001, 1, 1, 4'b1000);
    run("R3 cmp overflow",        CMP, 16'h0001, 16'h8000, 0, 0, 16'h7FFF, 0, 1, 4'b1001);
    run("R1 R3 cmp equal",        CMP, 16'h1234, 16'h1234, 0, 0, 16'h0000, 0, 1, 4'b1100);
  endtask

  task automatic t_dadd();
    run("R4 dadd ripple nines",   DADD, 16'h1999, 16'h0001, 0, 0, 16'h2000, 1, 1, 4'b0000);
    run("R4 dadd word carry out", DADD, 16'h9999, 16'h0000, 1, 0, 16'h0000, 1, 1, 4'b1100);
    run("R4 R9 dadd byte",        DADD, 16'hAB45, 16'hCD38, 0, 1, 16'h0083, 1, 1, 4'b0010);
    run("R4 R9 dadd byte carry",  DADD, 16'h0099, 16'h0001, 0, 1, 16'h0000, 1, 1, 4'b1100);
  endtask

  task automatic t_logic();
    run("R5 and",                 AND_, 16'hF0F0, 16'h0FF0, 0, 0, 16'h00F0, 1, 1, 4'b1000);
    run("R1 R5 bit zero",         BIT, 16'h000F, 16'h00F0, 0, 0, 16'h0000, 0, 1, 4'b0100);
    run("R5 xor both msb",        XOR_, 16'h8001, 16'h8003, 0, 0, 16'h0002, 1, 1, 4'b1001);
    run("R5 R9 xor byte",         XOR_, 16'h1280, 16'h3481, 0, 1, 16'h0001, 1, 1, 4'b1001);
  endtask

  task automatic t_moves();
    run("R6 bic",                 BIC, 16'h00FF, 16'h1234, 0, 0, 16'h1200, 1, 0, 4'b0000);
    run("R6 bis",                 BIS, 16'h0F00, 16'h1234, 0, 0, 16'h1F34, 1, 0, 4'b0000);
    run("R6 mov",                 MOV, 16'hBEEF, 16'h1234, 1, 0, 16'hBEEF, 1, 0, 4'b0000);
    run("R6 R9 mov byte",         MOV, 16'hBEEF, 16'h1234, 0, 1, 16'h00EF, 1, 0, 4'b0000);
    checks++;
    if ({fc, fz, fn, fv} !== 4'b0000) begin
      errors++;
      $display("FAIL R6 flags on mov: got %b expected 0000", {fc, fz, fn, fv});
    end
  endtask

  task automatic t_shift();
    run("R7 rra word",            RRA, 16'h0000, 16'h8003, 0, 0, 16'hC001, 1, 1, 4'b1010);
    run("R7 R9 rra byte",         RRA, 16'h0000, 16'h1281, 0, 1, 16'h00C0, 1, 1, 4'b1010);
    run("R7 rrc carry in",        RRC, 16'h0000, 16'h0002, 1, 0, 16'h8001, 1, 1, 4'b0010);
    run("R7 rrc to zero",         RRC, 16'h0000, 16'h0001, 0, 0, 16'h0000, 1, 1, 4'b1100);
    run("R7 R9 rrc byte",         RRC, 16'h0000, 16'hFF00, 1, 1, 16'h0080, 1, 1, 4'b0010);
  endtask

  task automatic t_swap_sxt();
    run("R8 swpb",                SWPB, 16'h0000, 16'h12AB, 0, 0, 16'hAB12, 1, 0, 4'b0000);
    run("R8 swpb byte flag",      SWPB, 16'h0000, 16'h12AB, 0, 1, 16'hAB12, 1, 0, 4'b0000);
    run("R8 sxt negative",        SXT, 16'h0000, 16'h1280, 0, 0, 16'hFF80, 1, 1, 4'b1010);
    run("R8 sxt zero",            SXT, 16'h0000, 16'hFF00, 0, 1, 16'h0000, 1, 1, 4'b0100);
  endtask

  task automatic t_byte();
    run("R9 add byte carry",      ADD, 16'h0080, 16'h0080, 0, 1, 16'h0000, 1, 1, 4'b1101);
    run("R9 add byte overflow",   ADD, 16'hFF7F, 16'hFF01, 0, 1, 16'h0080, 1, 1, 4'b0011);
    run("R9 sub byte borrow",     SUB, 16'h0001, 16'h0100, 0, 1, 16'h00FF, 1, 1, 4'b0010);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    op = '0; src = '0; dst = '0; cin = 1'b0; bsel = 1'b0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_add();
    t_sub();
    t_dadd();
    t_logic();
    t_moves();
    t_shift();
    t_swap_sxt();
    t_byte();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule